// File: doc/BRIEF.md
# Fast Ethernet transmit coder

This block is the 100 Mb/s transmit coding path of an Ethernet physical layer. It runs on the serial bit clock and asks for one 4-bit MII nibble every five clocks. It turns each nibble into a 5-bit code group and wraps each frame in start and end delimiters. It then XORs the serial code stream with an 11-bit side-stream scrambler and drives a three-level line symbol. Each symbol is a 2-bit signed value that the analog driver turns into MLT-3.

A control input selects a raw-code bypass mode, which is only honoured while auto-negotiation is off. In bypass the error pin and the four data pins form a 5-bit word that is already scrambled. That word skips both the nibble mapping and the scrambler and goes straight to the serializer and the line encoder.

Top module: `fetx_coder`

## Requirements
- R1: `nib_take` is high for one cycle in every five, and the first of these is the first cycle after reset release. The MII inputs are sampled at the rising edge that ends a `nib_take` cycle. The resulting code group then leaves MSB first over the next five cycles, and its last bit falls in the next `nib_take` cycle.
- R2: A data nibble inside a frame maps to its 5-bit group. For hex 0..F the groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: Outside a frame, every slot sends the idle group 11111.
- R4: The first slot with `tx_en` high after idle sends 11000, and the slot after it sends 10001, whatever the data is. Data mapping starts in the third slot.
- R5: The first slot with `tx_en` low after frame data sends 01101, the next sends 00111, and idle follows.
- R6: A data slot with both `tx_en` and `tx_er` high sends the halt group 00100 in place of the mapped nibble.
- R7: Outside bypass, `line_bit` is the code bit XOR a keystream bit k = s[10]^s[8]. Here s is an 11-bit register loaded with `LFSR_SEED` at reset. Every cycle s shifts left and takes k in as its new bit 0, and it keeps doing so during bypass.
- R8: With `bypass_en`=1 and `autoneg_on`=0 at a slot, the group is {`tx_er`,`txd`}, sent unscrambled with no delimiters. The frame state returns to idle, so a frame that continues after bypass starts again with 11000.
- R9: While `autoneg_on`=1, `bypass_en` has no effect and normal coding applies.
- R10: `mlt_out` codes 00 as 0, 01 as +1 and 11 as −1, and it is 0 after reset. In the cycle after a 1 on `line_bit` it moves one step along 0, +1, 0, −1. After a 0 it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Raw-code bypass control bit |
| autoneg_on | input | 1 | Auto-negotiation enabled; blocks bypass |
| tx_en | input | 1 | MII transmit enable |
| tx_er | input | 1 | MII transmit error; MSB of the raw word in bypass |
| txd | input | 4 | MII transmit nibble |
| nib_take | output | 1 | Inputs are sampled at the end of this cycle |
| line_bit | output | 1 | Scrambled serial bit for this cycle |
| mlt_out | output | 2 | Three-level line symbol, 2-bit signed |

## Verification
The assertions assume that the MII inputs and the mode inputs stay stable across the rising edge that ends a `nib_take` cycle. They also assume reset is held for at least one edge, so that the shift register, the frame state and the line level start from known values. The stimulus changes inputs only shortly after a falling edge in a `nib_take` cycle and holds them for the whole slot. It releases reset just after a rising edge.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;
  localparam int LFSR_W = 11;
  localparam int TAP_B  = 9;

  typedef enum logic [1:0] {FR_IDLE, FR_SENDK, FR_DATA, FR_SENDR} fr_state_e;

  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CG_HALT = 5'b00100;

  function automatic logic [CODE_W-1:0] map_nib(input logic [NIB_W-1:0] n);
    logic [CODE_W-1:0] c;
    unique case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic lfsr_tap(input logic [LFSR_W-1:0] s);
    return s[LFSR_W-1] ^ s[TAP_B-1];
  endfunction

  function automatic logic [1:0] mlt_level(input logic [1:0] phase);
    logic [1:0] l;
    unique case (phase)
      2'd1:    l = 2'b01;
      2'd3:    l = 2'b11;
      default: l = 2'b00;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/fetx_framer.sv
module fetx_framer
  import fetx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              byp_eff,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  output logic [CODE_W-1:0] code
);
  fr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    code    = CG_IDLE;
    if (byp_eff) begin
      code    = {tx_er, txd};
      state_d = FR_IDLE;
    end else begin
      unique case (state_q)
        FR_IDLE: if (tx_en) begin
          code    = CG_J;
          state_d = FR_SENDK;
        end
        FR_SENDK: begin
          code    = CG_K;
          state_d = FR_DATA;
        end
        FR_DATA: if (tx_en) begin
          code = tx_er ? CG_HALT : map_nib(txd);
        end else begin
          code    = CG_T;
          state_d = FR_SENDR;
        end
        default: begin
          code    = CG_R;
          state_d = FR_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= FR_IDLE;
    else if (load) state_q <= state_d;
  end
endmodule

// File: rtl/fetx_serializer.sv
module fetx_serializer
  import fetx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              byp_eff,
  output logic              load,
  output logic              ser_bit,
  output logic              byp_q
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sh_q;

  assign load    = (cnt_q == '0);
  assign ser_bit = sh_q[CODE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '1;
      byp_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (load) begin
        sh_q  <= code;
        byp_q <= byp_eff;
      end else begin
        sh_q <= {sh_q[CODE_W-2:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/fetx_scrambler.sv
module fetx_scrambler
  import fetx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 11'h5A3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_bit,
  input  logic byp_q,
  output logic line_bit
);
  logic [LFSR_W-1:0] s_q;
  logic              ks;

  assign ks       = lfsr_tap(s_q);
  assign line_bit = byp_q ? ser_bit : (ser_bit ^ ks);

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= {s_q[LFSR_W-2:0], ks};
  end
endmodule

// File: rtl/fetx_mlt3.sv
module fetx_mlt3
  import fetx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_bit,
  output logic [1:0] mlt_out
);
  logic [1:0] phase_q;

  assign mlt_out = mlt_level(phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= 2'd0;
    else if (line_bit) phase_q <= phase_q + 2'd1;
  end
endmodule

// File: rtl/fetx_coder.sv
module fetx_coder
  import fetx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 11'h5A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic              autoneg_on,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  output logic              nib_take,
  output logic              line_bit,
  output logic [1:0]        mlt_out
);
  logic              byp_eff;
  logic              byp_q;
  logic              ser_bit;
  logic [CODE_W-1:0] code;

  assign byp_eff = bypass_en & ~autoneg_on;

  fetx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .load(nib_take), .byp_eff(byp_eff),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .code(code)
  );

  fetx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .code(code), .byp_eff(byp_eff),
    .load(nib_take), .ser_bit(ser_bit), .byp_q(byp_q)
  );

  fetx_scrambler #(.SEED(LFSR_SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .byp_q(byp_q),
    .line_bit(line_bit)
  );

  fetx_mlt3 u_mlt (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .mlt_out(mlt_out)
  );
endmodule

// File: rtl/fetx_coder_chk.sv
module fetx_coder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nib_take,
  input logic       byp_eff,
  input logic       tx_er,
  input logic       line_bit,
  input logic [1:0] mlt_out
);
  logic [2:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        since_q <= 3'd4;
    else if (nib_take) since_q <= 3'd0;
    else               since_q <= since_q + 3'd1;
  end

  AST_TAKE_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    nib_take == (since_q == 3'd4)); // R1
  AST_BYPASS_MSB_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_take && byp_eff) |=> (line_bit == $past(tx_er))); // R8
  AST_MLT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mlt_out != 2'b10); // R10
  AST_MLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_bit |=> $stable(mlt_out)); // R10
  AST_MLT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    line_bit |=> (mlt_out != $past(mlt_out))); // R10
  AST_MLT_VIA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (line_bit && mlt_out != 2'b00) |=> (mlt_out == 2'b00)); // R10
endmodule

bind fetx_coder fetx_coder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nib_take(nib_take), .byp_eff(byp_eff),
  .tx_er(tx_er), .line_bit(line_bit), .mlt_out(mlt_out)
);

// File: tb/fetx_coder_tb.sv
module fetx_coder_tb;
  localparam logic [10:0] TB_SEED = 11'h5A3;
  localparam logic [4:0] TB_MAP [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                                         5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
  localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                         E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bypass_en = 1'b0, autoneg_on = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  wire nib_take, line_bit;
  wire [1:0] mlt_out;

  fetx_coder #(.LFSR_SEED(TB_SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .autoneg_on(autoneg_on),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .nib_take(nib_take),
    .line_bit(line_bit), .mlt_out(mlt_out)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_take = 0;
  bit done = 1'b0;
  logic [10:0] b_s;
  logic [1:0]  b_ph;
  logic        ks;
  logic [4:0]  sh_raw = '0, sh_dsc = '0, nr, nd;
  logic [4:0]  g_raw [0:255];
  logic [4:0]  g_dsc [0:255];

  function automatic logic [1:0] exp_level(input logic [1:0] ph);
    if (ph == 2'd1) return 2'b01;
    if (ph == 2'd3) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Own keystream model (R7)
  always @(posedge clk) begin
    if (!rst_n) b_s <= TB_SEED;
    else        b_s <= {b_s[9:0], b_s[10] ^ b_s[8]};
  end

  // Group capture and line level model (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      ks = b_s[10] ^ b_s[8];
      nr = {sh_raw[3:0], line_bit};
      nd = {sh_dsc[3:0], line_bit ^ ks};
      check(mlt_out === exp_level(b_ph), "R10 mlt level", {6'd0, mlt_out}, {6'd0, exp_level(b_ph)});
      if (line_bit) b_ph = b_ph + 2'd1;
      if (nib_take) begin
        g_raw[n_take[7:0]] = nr;
        g_dsc[n_take[7:0]] = nd;
        n_take++;
      end
      sh_raw = nr;
      sh_dsc = nd;
    end else begin
      b_ph   = 2'd0;
      n_take = 0;
    end
  end

  task automatic send(input bit byp, input bit an, input bit en, input bit er,
                      input logic [3:0] d, output int idx);
    forever begin
      @(negedge clk); #1;
      if (nib_take) break;
    end
    bypass_en = byp; autoneg_on = an; tx_en = en; tx_er = er; txd = d;
    idx = n_take;
  endtask

  task automatic expect_grp(input int idx, input bit raw, input logic [4:0] exp, input string tag);
    while (n_take <= idx) begin
      @(negedge clk); #1;
    end
    if (raw) check(g_raw[idx] === exp, tag, {3'd0, g_raw[idx]}, {3'd0, exp});
    else     check(g_dsc[idx] === exp, tag, {3'd0, g_dsc[idx]}, {3'd0, exp});
  endtask

  task automatic t_reset();
    int bad;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(nib_take === 1'b1, "R1 first take after reset", {7'd0, nib_take}, 8'd1);
    check(mlt_out === 2'b00, "R10 reset level", {6'd0, mlt_out}, 8'd0);
    bad = 0;
    for (int c = 1; c < 20; c++) begin
      @(negedge clk); #1;
      if (nib_take !== ((c % 5) == 0)) bad++;
    end
    check(bad == 0, "R1 take cadence", bad[7:0], 8'd0);
  endtask

  task automatic t_idle();
    int ix [3];
    for (int i = 0; i < 3; i++) send(0, 0, 0, 0, 4'h0, ix[i]);
    for (int i = 0; i < 3; i++) expect_grp(ix[i], 0, E_IDLE, "R3 R7 idle");
  endtask

  task automatic t_frame_all();
    int ix [21];
    send(0, 0, 1, 0, 4'h5, ix[0]);
    send(0, 0, 1, 0, 4'h5, ix[1]);
    for (int n = 0; n < 16; n++) send(0, 0, 1, 0, n[3:0], ix[n + 2]);
    for (int i = 18; i < 21; i++) send(0, 0, 0, 0, 4'h0, ix[i]);
    expect_grp(ix[0], 0, E_J, "R4 start J");
    expect_grp(ix[1], 0, E_K, "R4 start K");
    for (int n = 0; n < 16; n++) expect_grp(ix[n + 2], 0, TB_MAP[n], "R2 R7 nibble map");
    expect_grp(ix[18], 0, E_T, "R5 end T");
    expect_grp(ix[19], 0, E_R, "R5 end R");
    expect_grp(ix[20], 0, E_IDLE, "R5 idle after end");
  endtask

  task automatic t_halt();
    int ix [8];
    send(0, 0, 1, 0, 4'hA, ix[0]);
    send(0, 0, 1, 1, 4'h3, ix[1]);
    send(0, 0, 1, 0, 4'h3, ix[2]);
    send(0, 0, 1, 1, 4'h9, ix[3]);
    send(0, 0, 1, 0, 4'hC, ix[4]);
    send(0, 0, 0, 1, 4'h0, ix[5]);
    send(0, 0, 0, 0, 4'h0, ix[6]);
    send(0, 0, 0, 0, 4'h0, ix[7]);
    expect_grp(ix[0], 0, E_J, "R4 J ignores data");
    expect_grp(ix[1], 0, E_K, "R4 K ignores data and error");
    expect_grp(ix[2], 0, TB_MAP[3], "R2 data after K");
    expect_grp(ix[3], 0, E_H, "R6 halt on error");
    expect_grp(ix[4], 0, TB_MAP[12], "R6 data after halt");
    expect_grp(ix[5], 0, E_T, "R5 T with error low en");
    expect_grp(ix[6], 0, E_R, "R5 R");
    expect_grp(ix[7], 0, E_IDLE, "R3 idle after frame");
  endtask

  task automatic t_bypass();
    int ix [9];
    send(1, 0, 1, 1, 4'hA, ix[0]);
    send(1, 0, 1, 0, 4'h3, ix[1]);
    send(1, 0, 0, 1, 4'hF, ix[2]);
    send(1, 0, 1, 0, 4'h0, ix[3]);
    send(0, 0, 1, 0, 4'h5, ix[4]);
    send(0, 0, 1, 0, 4'h5, ix[5]);
    send(0, 0, 1, 0, 4'h1, ix[6]);
    send(0, 0, 0, 0, 4'h0, ix[7]);
    send(0, 0, 0, 0, 4'h0, ix[8]);
    expect_grp(ix[0], 1, 5'b11010, "R8 raw word er=1");
    expect_grp(ix[1], 1, 5'b00011, "R8 raw word er=0");
    expect_grp(ix[2], 1, 5'b11111, "R8 raw word all ones");
    expect_grp(ix[3], 1, 5'b00000, "R8 raw word zero");
    expect_grp(ix[4], 0, E_J, "R8 R7 frame restarts with J");
    expect_grp(ix[5], 0, E_K, "R8 K after bypass");
    expect_grp(ix[6], 0, TB_MAP[1], "R7 keystream continued through bypass");
    expect_grp(ix[7], 0, E_T, "R5 T after bypass frame");
  endtask

  task automatic t_an_block();
    int ix [6];
    send(1, 1, 0, 1, 4'h7, ix[0]);
    send(1, 1, 1, 0, 4'h5, ix[1]);
    send(1, 1, 1, 0, 4'h5, ix[2]);
    send(1, 1, 1, 0, 4'h8, ix[3]);
    send(1, 1, 0, 0, 4'h0, ix[4]);
    send(0, 0, 0, 0, 4'h0, ix[5]);
    expect_grp(ix[0], 0, E_IDLE, "R9 bypass blocked, idle");
    expect_grp(ix[1], 0, E_J, "R9 framing J");
    expect_grp(ix[2], 0, E_K, "R9 framing K");
    expect_grp(ix[3], 0, TB_MAP[8], "R9 mapped data");
    expect_grp(ix[4], 0, E_T, "R9 framing T");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_frame_all();
    t_halt();
    t_bypass();
    t_an_block();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule